// File: doc/BRIEF.md
# Five-Source Word Interleaver for a 20-Bit Serial Link

This block collects 40-bit words from five memory sources and turns them into a single stream of 20-bit words for a serializer. Each data round lasts nine link steps. Sources 1 to 4 each own two consecutive steps: the low half of their word goes out first, then the high half. Source 5 owns the last step alone, and only its low 20 bits are used. Before the data rounds, source 1 also supplies a fixed number of header words, sent over the same port.

A pulse on the start input opens a transfer. The block first sends a start-of-header control word, then the header, then a start-of-data control word, then `N_ROUNDS` data rounds, and finally an end-of-data control word. A qualifying input from source 1 (`dav_i`) gates every header and data step. While it is low, the schedule holds its position and no word is presented. A stop request cuts the transfer short at the next round boundary. A round-sync output marks the first word of every data round, so the sources can align their own step counters to it.

Top module: `link_ilv_top`

## Requirements
- R1: While reset is held and just after it is released, `link_valid_o`, `link_ctl_o`, `round_sync_o`, `link_data_o` and `src_rd_o` are all zero.
- R2: A start pulse sampled while idle puts the start-of-header control word (`link_ctl_o`=1, `link_data_o`=20'h00001) on the link two clock edges later. A start pulse while a transfer is running has no effect.
- R3: After the start-of-header word come `N_HDR` header words from source 1, each sent as two data words, low half (bits 19:0) then high half (bits 39:20). The start-of-data control word (20'h00002) follows them.
- R4: Each data round presents, in order: sources 1, 2, 3 and 4, each as low half then high half, then source 5 bits 19:0. That makes nine data words. Source k is read from `src_word_i[(k-1)*40 +: 40]`.
- R5: `src_rd_o` bit k-1 pulses for exactly the cycle in which source k's word is taken, which is the cycle before its low half appears on the link. At most one bit is high at a time.
- R6: `round_sync_o` is high together with the first word of every data round and at no other time.
- R7: While `dav_i` is low in a header or data step, no read strobe is issued, the next cycle shows `link_valid_o`=0, and the schedule resumes at the same position. Control words do not wait for `dav_i`.
- R8: After `N_ROUNDS` complete rounds, the end-of-data control word (20'h00003) is sent and the block returns to idle.
- R9: A stop request seen during a transfer ends it after the round in progress (after the first round if it comes before the data phase). End-of-data is still sent exactly once. A stop request while idle is ignored.
- R10: `link_valid_o` is high exactly in the cycles that present a control or data word. Otherwise `link_ctl_o`, `link_data_o` and `round_sync_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Opens a transfer when idle |
| stop_i | input | 1 | Request to end at the next round boundary |
| dav_i | input | 1 | Source-1 data qualifier gating header and data steps |
| src_word_i | input | 200 | Five 40-bit source words, source 1 in the low bits |
| src_rd_o | output | 5 | Per-source read strobe, bit 0 for source 1 |
| link_data_o | output | 20 | Link word |
| link_ctl_o | output | 1 | Link word is a control code |
| link_valid_o | output | 1 | Link word present |
| round_sync_o | output | 1 | First word of a data round |

## Verification
The sharpest collision is a stop request that falls in the final data round, where the stop path and the natural end of the transfer both want to close the same round. A second case is the same request landing in a cycle where `dav_i` is low on the source-5 step. The bench drives both cases: stop on exactly the source-5 step of the last round, once with the qualifier high and once with it low. A behavioural queue model expects exactly one end-of-data word after that round, with no missing or extra data words. Stop requests placed in the header, in mid-data and while idle are judged against the same model on every cycle.

// File: rtl/link_ilv_pkg.sv
// Shared constants and types for the five-source link interleaver.
// Assumes a fixed nine-step round: four full-word sources, one half-word source.
package link_ilv_pkg;
    localparam int WORD_W = 40;
    localparam int HALF_W = 20;
    localparam int N_SRC  = 5;
    localparam int N_SLOT = 9;
    localparam int SRC_W  = $clog2(N_SRC);
    localparam int STEP_W = $clog2(N_SLOT);

    localparam logic [HALF_W-1:0] CODE_SOH = 20'h00001;
    localparam logic [HALF_W-1:0] CODE_SOD = 20'h00002;
    localparam logic [HALF_W-1:0] CODE_EOD = 20'h00003;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SOH, PH_HDR, PH_SOD, PH_DATA, PH_EOD
    } phase_t;

    typedef enum logic [1:0] {
        EMIT_NONE, EMIT_CODE, EMIT_LO, EMIT_HI
    } emit_t;
endpackage

// File: rtl/link_ilv_seq.sv
// Transfer sequencer: walks start-of-header, header words, start-of-data,
// the nine-step data rounds and end-of-data, and tells the word path what to
// emit each cycle. Assumes N_ROUNDS >= 1 and N_HDR >= 1; dav_i gates only
// header and data steps, control words never wait.
module link_ilv_seq
    import link_ilv_pkg::*;
#(
    parameter int N_ROUNDS = 4,
    parameter int N_HDR    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              dav_i,
    output emit_t             emit_o,
    output logic [HALF_W-1:0] code_o,
    output logic [SRC_W-1:0]  src_o,
    output logic              first_o
);
    localparam int RND_W = (N_ROUNDS > 1) ? $clog2(N_ROUNDS) : 1;
    localparam int HDR_W = (N_HDR > 1) ? $clog2(N_HDR) : 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_SLOT - 1);
    localparam logic [RND_W-1:0]  LAST_RND  = RND_W'(N_ROUNDS - 1);
    localparam logic [HDR_W-1:0]  LAST_HDR  = HDR_W'(N_HDR - 1);

    phase_t            phase_q, phase_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic [RND_W-1:0]  rnd_q, rnd_d;
    logic [HDR_W-1:0]  hdr_q, hdr_d;
    logic              half_q, half_d;
    logic              stop_q, stop_d;
    logic              end_round;

    // A round closes the transfer when it is the last one or a stop is pending.
    assign end_round = stop_q || stop_i || (rnd_q == LAST_RND);

    // Next-state and per-cycle emission decision.
    always_comb begin
        phase_d = phase_q;
        step_d  = step_q;
        rnd_d   = rnd_q;
        hdr_d   = hdr_q;
        half_d  = half_q;
        stop_d  = stop_q;
        emit_o  = EMIT_NONE;
        code_o  = '0;
        src_o   = '0;
        first_o = 1'b0;
        if (phase_q != PH_IDLE && stop_i) begin
            stop_d = 1'b1;
        end
        case (phase_q)
            PH_IDLE: begin
                if (start_i) begin
                    phase_d = PH_SOH;
                end
            end
            PH_SOH: begin
                emit_o  = EMIT_CODE;
                code_o  = CODE_SOH;
                phase_d = PH_HDR;
                hdr_d   = '0;
                half_d  = 1'b0;
            end
            PH_HDR: begin
                if (dav_i) begin
                    emit_o = half_q ? EMIT_HI : EMIT_LO;
                    half_d = ~half_q;
                    if (half_q) begin
                        if (hdr_q == LAST_HDR) begin
                            phase_d = PH_SOD;
                            hdr_d   = '0;
                        end else begin
                            hdr_d = hdr_q + 1'b1;
                        end
                    end
                end
            end
            PH_SOD: begin
                emit_o  = EMIT_CODE;
                code_o  = CODE_SOD;
                phase_d = PH_DATA;
                step_d  = '0;
                rnd_d   = '0;
            end
            PH_DATA: begin
                if (dav_i) begin
                    emit_o  = (step_q == LAST_STEP || !step_q[0]) ? EMIT_LO : EMIT_HI;
                    src_o   = SRC_W'(step_q >> 1);
                    first_o = (step_q == '0);
                    if (step_q == LAST_STEP) begin
                        step_d = '0;
                        if (end_round) begin
                            phase_d = PH_EOD;
                            rnd_d   = '0;
                        end else begin
                            rnd_d = rnd_q + 1'b1;
                        end
                    end else begin
                        step_d = step_q + 1'b1;
                    end
                end
            end
            PH_EOD: begin
                emit_o  = EMIT_CODE;
                code_o  = CODE_EOD;
                phase_d = PH_IDLE;
                stop_d  = 1'b0;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
            rnd_q   <= '0;
            hdr_q   <= '0;
            half_q  <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            step_q  <= step_d;
            rnd_q   <= rnd_d;
            hdr_q   <= hdr_d;
            half_q  <= half_d;
            stop_q  <= stop_d;
        end
    end

    // End-of-data is a single cycle, followed by idle.
    assert_eod_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_EOD) |=> (phase_q == PH_IDLE));

    // Without dav_i the data schedule keeps its place.
    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA && !dav_i) |=> (phase_q == PH_DATA && $stable(step_q) && $stable(rnd_q)));

    // Idle is left only through a start pulse; stop alone does nothing.
    assert_idle_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && !start_i) |=> (phase_q == PH_IDLE));

    // The round counter never passes the configured number of rounds.
    assert_round_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_q <= LAST_RND) && (step_q <= LAST_STEP));
endmodule

// File: rtl/link_ilv_mux.sv
// Word path: selects the scheduled source, issues its read strobe, splits
// its 40-bit word into halves and registers the link outputs. Assumes the
// sequencer requests a high half only right after that source's low half.
module link_ilv_mux
    import link_ilv_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC*WORD_W-1:0] src_word_i,
    input  emit_t                   emit_i,
    input  logic [HALF_W-1:0]       code_i,
    input  logic [SRC_W-1:0]        src_i,
    input  logic                    first_i,
    output logic [N_SRC-1:0]        src_rd_o,
    output logic [HALF_W-1:0]       link_data_o,
    output logic                    link_ctl_o,
    output logic                    link_valid_o,
    output logic                    round_sync_o
);
    logic [WORD_W-1:0] words [N_SRC];
    logic [WORD_W-1:0] sel_word;
    logic [HALF_W-1:0] hold_q;

    // Unpack the source ports and decode one read strobe per source.
    for (genvar k = 0; k < N_SRC; k++) begin : g_src
        assign words[k]    = src_word_i[k*WORD_W +: WORD_W];
        assign src_rd_o[k] = (emit_i == EMIT_LO) && (src_i == SRC_W'(k));
    end

    // Pick the word of the scheduled source.
    always_comb begin
        sel_word = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (src_i == SRC_W'(k)) begin
                sel_word = words[k];
            end
        end
    end

    // Keep the upper half for the following step; register the link word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q       <= '0;
            link_data_o  <= '0;
            link_ctl_o   <= 1'b0;
            link_valid_o <= 1'b0;
            round_sync_o <= 1'b0;
        end else begin
            link_ctl_o   <= (emit_i == EMIT_CODE);
            link_valid_o <= (emit_i != EMIT_NONE);
            round_sync_o <= first_i;
            case (emit_i)
                EMIT_CODE: link_data_o <= code_i;
                EMIT_LO: begin
                    link_data_o <= sel_word[HALF_W-1:0];
                    hold_q      <= sel_word[WORD_W-1:HALF_W];
                end
                EMIT_HI:   link_data_o <= hold_q;
                default:   link_data_o <= '0;
            endcase
        end
    end

    // Only one source is read in any cycle.
    assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_rd_o));

    // Round sync marks a presented data word, never a control word.
    assert_sync_on_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        round_sync_o |-> (link_valid_o && !link_ctl_o));

    // A control flag without a presented word is illegal.
    assert_ctl_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        link_ctl_o |-> link_valid_o);

    // A read strobe is followed by a data word on the link.
    assert_strobe_then_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_rd_o) |=> (link_valid_o && !link_ctl_o));
endmodule

// File: rtl/link_ilv_top.sv
// Top of the five-source link interleaver: joins the transfer sequencer
// and the word path. Assumes sources hold their word until their strobe.
module link_ilv_top
    import link_ilv_pkg::*;
#(
    parameter int N_ROUNDS = 4,
    parameter int N_HDR    = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    stop_i,
    input  logic                    dav_i,
    input  logic [N_SRC*WORD_W-1:0] src_word_i,
    output logic [N_SRC-1:0]        src_rd_o,
    output logic [HALF_W-1:0]       link_data_o,
    output logic                    link_ctl_o,
    output logic                    link_valid_o,
    output logic                    round_sync_o
);
    emit_t             emit;
    logic [HALF_W-1:0] code;
    logic [SRC_W-1:0]  src_sel;
    logic              first;

    link_ilv_seq #(
        .N_ROUNDS(N_ROUNDS),
        .N_HDR   (N_HDR)
    ) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .stop_i (stop_i),
        .dav_i  (dav_i),
        .emit_o (emit),
        .code_o (code),
        .src_o  (src_sel),
        .first_o(first)
    );

    link_ilv_mux mux_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_word_i  (src_word_i),
        .emit_i      (emit),
        .code_i      (code),
        .src_i       (src_sel),
        .first_i     (first),
        .src_rd_o    (src_rd_o),
        .link_data_o (link_data_o),
        .link_ctl_o  (link_ctl_o),
        .link_valid_o(link_valid_o),
        .round_sync_o(round_sync_o)
    );
endmodule

// File: tb/link_ilv_top_tb_top.sv
// Bench: a queue-based reference model of the expected link stream, compared every cycle.
module link_ilv_top_tb_top;
    import link_ilv_pkg::*;

    localparam int NR = 4;
    localparam int NH = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                    rst_n, start_i, stop_i, dav_i;
    logic [N_SRC*WORD_W-1:0] src_word;
    logic [N_SRC-1:0]        src_rd;
    logic [HALF_W-1:0]       ldata;
    logic                    lctl, lvalid, lsync;

    int          cnt [N_SRC];
    logic [39:0] cap [N_SRC];
    int          checks = 0;
    int          errors = 0;

    typedef struct {
        int          kind;   // 0 control, 1 low half, 2 high half
        int          src;
        logic [19:0] code;
        bit          first;
        bit          last;
        string       tag;
    } ent_t;

    ent_t q[$];
    bit   pend = 1'b0;

    link_ilv_top #(.N_ROUNDS(NR), .N_HDR(NH)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .dav_i(dav_i),
        .src_word_i(src_word), .src_rd_o(src_rd), .link_data_o(ldata),
        .link_ctl_o(lctl), .link_valid_o(lvalid), .round_sync_o(lsync)
    );

    function automatic logic [39:0] mkword(int k, int n);
        return {4'(k + 1), 12'(n), 4'(k + 8), 4'hA, 16'((n * 37 + k * 101) & 16'hFFFF)};
    endfunction

    always_comb begin
        for (int k = 0; k < N_SRC; k++) src_word[k*WORD_W +: WORD_W] = mkword(k, cnt[k]);
    end

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic push(int kind, int src, logic [19:0] code, bit first, bit last, string tag);
        ent_t e;
        e.kind = kind; e.src = src; e.code = code; e.first = first; e.last = last; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic build_run();
        push(0, 0, CODE_SOH, 0, 0, "R2");
        for (int h = 0; h < NH; h++) begin
            push(1, 0, '0, 0, 0, "R3");
            push(2, 0, '0, 0, 0, "R3");
        end
        push(0, 0, CODE_SOD, 0, 0, "R3");
        for (int r = 0; r < NR; r++) begin
            for (int s = 0; s < N_SLOT; s++) begin
                push((s % 2 == 0) ? 1 : 2, s / 2, '0, s == 0, s == N_SLOT - 1, "R4");
            end
        end
        push(0, 0, CODE_EOD, 0, 0, "R8");
    endtask

    // One clock of stimulus, model step and comparison; entered and left at a falling edge.
    task automatic cyc(bit st, bit sp, bit dv);
        bit busy, took, stall;
        ent_t h, e;
        logic [N_SRC-1:0] exp_rd;
        logic [19:0] val;
        bit exp_valid, exp_ctl, exp_sync;
        string exp_tag;
        start_i = st; stop_i = sp; dav_i = dv;
        #1;
        busy = (q.size() > 0);
        if (busy && sp) pend = 1'b1;
        took = 1'b0; stall = 1'b0; exp_rd = '0; val = '0;
        h.kind = 0; h.src = 0; h.code = '0; h.first = 0; h.last = 0; h.tag = "R10";
        if (busy) begin
            h = q[0];
            if (h.kind == 0 || dv) took = 1'b1;
            else stall = 1'b1;
        end
        if (took) begin
            case (h.kind)
                0: val = h.code;
                1: begin
                    cap[h.src] = mkword(h.src, cnt[h.src]);
                    val = cap[h.src][19:0];
                    exp_rd[h.src] = 1'b1;
                end
                default: val = cap[h.src][39:20];
            endcase
            void'(q.pop_front());
            if (h.last && pend) begin
                while (q[0].kind != 0) void'(q.pop_front());
                e = q.pop_front();
                e.tag = "R9";
                q.push_front(e);
            end
        end
        if (q.size() == 0) pend = 1'b0;
        if (!busy && st) build_run();
        chk(src_rd == exp_rd, stall ? "R7" : "R5", "read strobe", 32'(src_rd), 32'(exp_rd));
        exp_valid = took;
        exp_ctl   = took && (h.kind == 0);
        exp_sync  = took && h.first;
        exp_tag   = took ? h.tag : (stall ? "R7" : "R10");
        @(posedge clk);
        #1;
        if (took && h.kind == 1) cnt[h.src]++;
        @(negedge clk);
        chk(lvalid == exp_valid, exp_tag, "link valid", 32'(lvalid), 32'(exp_valid));
        chk(lctl == exp_ctl, exp_tag, "control flag", 32'(lctl), 32'(exp_ctl));
        chk(ldata == (took ? val : 20'h0), exp_tag, "link word", 32'(ldata), 32'(took ? val : 20'h0));
        chk(lsync == exp_sync, "R6", "round sync", 32'(lsync), 32'(exp_sync));
    endtask

    function automatic bit dav_pat(int pat, int i);
        case (pat)
            1:       return (i % 5 != 2) && (i % 7 != 3);
            2:       return (i != 43);
            default: return 1'b1;
        endcase
    endfunction

    task automatic drain(int pat, int start_at, int stop_at);
        int i = 0;
        while (q.size() > 0 && i < 2000) begin
            cyc(i == start_at, i == stop_at, dav_pat(pat, i));
            i++;
        end
        for (int j = 0; j < 3; j++) cyc(0, 0, 1);
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < N_SRC; k++) begin
            cnt[k] = 0;
            cap[k] = '0;
        end
        rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0; dav_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(!lvalid && !lctl && !lsync, "R1", "flags in reset", {lvalid, lctl, lsync}, 0);
        chk(ldata == '0 && src_rd == '0, "R1", "data in reset", {src_rd, ldata}, 0);
        rst_n = 1'b1;
        cyc(0, 0, 1);
        chk(ldata == '0 && !lvalid, "R1", "after release", {lvalid, ldata}, 0);
        // Plain run; a second start in mid-transfer must be ignored (R2).
        cyc(1, 0, 1); drain(0, 10, -1);
        // Qualifier dropping at scattered steps (R7).
        cyc(1, 0, 1); drain(1, -1, -1);
        // Stop in the second data round (R9).
        cyc(1, 0, 1); drain(0, -1, 20);
        // Stop during the header: one data round only (R9).
        cyc(1, 0, 1); drain(0, -1, 3);
        // Stop while idle is ignored; the next run is complete (R9).
        cyc(0, 1, 1); cyc(0, 0, 1);
        cyc(1, 0, 1); drain(0, -1, -1);
        // Stop on the source-5 step of the last round while the qualifier is low.
        cyc(1, 0, 1); drain(2, -1, 43);
        // Stop exactly on the natural end of the last round (R8, R9).
        cyc(1, 0, 1); drain(0, -1, 43);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule